// File: doc/BRIEF.md
# Single-Bus Load-G Processor

A small 16-bit processor whose registers all exchange data over one shared 16-bit bus. It holds a program counter (PC), an instruction register (IR), a memory address register (MAR), a memory buffer register (MBR) and one general-purpose register, G. Each instruction runs through four numbered subcycles, and each subcycle has three clock phases. In phase 0 the selected source drives the bus. In phase 1 the first destination loads from the bus. In phase 2 the second destination loads. Subcycles 1 and 2 fetch the instruction. The opcode is then decoded one-hot, and each decoder line is ANDed with the subcycle and phase lines to form the control strobes for subcycles 3 and 4.

Only three behaviours are defined: load G from memory, halt, and no operation. Every instruction therefore takes 12 clocks, unless it halts. Program memory is a word-addressed array inside the block. It is filled through a write port, usually while reset is held, and the processor starts at address 0 when reset is released. The environment observes the halt flag, the PC and the value in G.

Top module: `sbus_cpu`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `pcOut` is 0, `halted` is 0 and `gOut` is 0.
- R2: Fetch reads the word at PC into IR. PC increments by exactly 1 at clock edge 12n+6, counted from the release of reset, where n is the number of instructions already completed. PC never changes by any other amount.
- R3: A word whose upper 4 bits are 6 (load G) copies the memory word into G at clock edge 12n+11. The address is the low 12 bits of the instruction word, with zeros placed above them on the bus. G changes at no other time.
- R4: A word whose upper 4 bits are 0 (halt) sets `halted` at clock edge 12n+7. At that point `pcOut` holds the address that follows the halt word.
- R5: Every other opcode value, for example F (word FFFF), 1 or A, acts as a no-operation. It advances the PC and leaves G and `halted` unchanged.
- R6: In any cycle, at most one of the PC, the MBR and the operand field drives the bus.
- R7: A register loads from the bus only while some source drives the bus. The MBR load from memory always comes one cycle after a MAR load.
- R8: Once `halted` is 1, it stays 1 until reset, and `pcOut` and `gOut` keep their values.
- R9: The program FFFF, 6004, 0000, 0000, BBBB placed at address 0 ends with `gOut` = BBBB, `halted` = 1 and `pcOut` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memWrEn | input | 1 | Program memory write enable |
| memWrAddr | input | 6 | Program memory write address |
| memWrData | input | 16 | Program memory write data |
| halted | output | 1 | Processor has executed a halt |
| pcOut | output | 12 | Program counter |
| gOut | output | 16 | G register contents |

## Verification
The checker watches, on every cycle, the properties that the control strobes and outputs must always satisfy. At most one source drives the bus. No register loads while the bus is undriven. The MBR load always follows a MAR load. PC moves only in steps of one. G changes only after a load-G strobe. Halt freezes the outputs. Only the directed programs can show the values that are actually moved: which memory word lands in G, the exact edge at which PC advances, G loads or the halt takes effect, and the fact that unused opcodes behave as no-operations.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int OP_W   = DATA_W - ADDR_W;

  typedef struct packed {
    logic srcPc;
    logic srcMbr;
    logic srcOpnd;
    logic ldMar;
    logic ldMbr;
    logic ldIr;
    logic incPc;
    logic ldG;
    logic setHalt;
  } strobe_t;
endpackage

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
#(
  parameter int NUM_SUB = 4,
  parameter int NUM_PH  = 3,
  parameter int LDG_OP  = 6,
  parameter int HLT_OP  = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  output strobe_t         strobe,
  output logic            halted
);
  localparam int SUB_W  = $clog2(NUM_SUB);
  localparam int PH_W   = $clog2(NUM_PH);
  localparam int N_DEC  = 1 << OP_W;

  logic [SUB_W-1:0] subIdx;
  logic [PH_W-1:0]  phIdx;
  logic [NUM_SUB-1:0] subLine;
  logic [NUM_PH-1:0]  phLine;
  logic [N_DEC-1:0]   decLine;

  // one-hot opcode decoder
  for (genvar i = 0; i < N_DEC; i++) begin : g_dec
    assign decLine[i] = (opcode == OP_W'(i));
  end
  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    assign subLine[s] = (subIdx == SUB_W'(s));
  end
  for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
    assign phLine[p] = (phIdx == PH_W'(p));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subIdx <= '0;
      phIdx  <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (phIdx == PH_W'(NUM_PH - 1)) begin
        phIdx  <= '0;
        subIdx <= (subIdx == SUB_W'(NUM_SUB - 1)) ? '0 : subIdx + 1'b1;
      end else begin
        phIdx <= phIdx + 1'b1;
      end
      if (strobe.setHalt) halted <= 1'b1;
    end
  end

  logic run, isLdg, isHlt, sc1, sc2, sc3, sc4;
  assign run   = !halted;
  assign isLdg = decLine[LDG_OP];
  assign isHlt = decLine[HLT_OP];
  assign sc1   = subLine[0];
  assign sc2   = subLine[1];
  assign sc3   = subLine[2];
  assign sc4   = subLine[3];

  always_comb begin
    strobe.srcPc   = run & sc1;
    strobe.srcMbr  = run & (sc2 | (sc4 & isLdg));
    strobe.srcOpnd = run & sc3 & isLdg;
    strobe.ldMar   = run & phLine[1] & (sc1 | (sc3 & isLdg));
    strobe.ldMbr   = run & phLine[2] & (sc1 | (sc3 & isLdg));
    strobe.ldIr    = run & phLine[1] & sc2;
    strobe.incPc   = run & phLine[2] & sc2;
    strobe.ldG     = run & phLine[1] & sc4 & isLdg;
    strobe.setHalt = run & phLine[0] & sc3 & isHlt;
  end
endmodule

// File: rtl/sbus_dpath.sv
module sbus_dpath
  import sbus_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              memWrEn,
  input  logic [MEM_AW-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] gOut
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mbr, ir, gReg, bus, memRd;
  logic [OP_W-1:0]   zeroSrc;

  assign zeroSrc = '0;

  always_ff @(posedge clk) begin
    if (memWrEn) mem[memWrAddr] <= memWrData;
  end
  assign memRd = mem[mar[MEM_AW-1:0]];

  // shared bus: one source per cycle, upper nibble from the zero source
  always_comb begin
    bus = '0;
    if (strobe.srcPc)   bus = {zeroSrc, pc};
    if (strobe.srcMbr)  bus = mbr;
    if (strobe.srcOpnd) bus = {zeroSrc, ir[ADDR_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc   <= '0;
      mar  <= '0;
      mbr  <= '0;
      ir   <= '0;
      gReg <= '0;
    end else begin
      if (strobe.ldMar) mar  <= bus[ADDR_W-1:0];
      if (strobe.ldMbr) mbr  <= memRd;
      if (strobe.ldIr)  ir   <= bus;
      if (strobe.incPc) pc   <= pc + 1'b1;
      if (strobe.ldG)   gReg <= bus;
    end
  end

  assign opcode = ir[DATA_W-1:ADDR_W];
  assign pcOut  = pc;
  assign gOut   = gReg;
endmodule

// File: rtl/sbus_cpu.sv
module sbus_cpu
  import sbus_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic [MEM_AW-1:0] memWrAddr,
  input  logic [DATA_W-1:0] memWrData,
  output logic              halted,
  output logic [ADDR_W-1:0] pcOut,
  output logic [DATA_W-1:0] gOut
);
  strobe_t         strobe;
  logic [OP_W-1:0] opcode;

  sbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .strobe(strobe), .halted(halted)
  );

  sbus_dpath #(.MEM_AW(MEM_AW)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .opcode(opcode), .pcOut(pcOut), .gOut(gOut)
  );
endmodule

// File: rtl/sbus_cpu_chk.sv
module sbus_cpu_chk
  import sbus_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input strobe_t           strobe,
  input logic              halted,
  input logic [ADDR_W-1:0] pcOut,
  input logic [DATA_W-1:0] gOut
);
  // R6
  one_bus_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.srcPc, strobe.srcMbr, strobe.srcOpnd}));

  // R7
  load_needs_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldMar | strobe.ldIr | strobe.ldG) |->
      (strobe.srcPc | strobe.srcMbr | strobe.srcOpnd));

  // R7
  mbr_after_mar_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ldMbr |-> $past(strobe.ldMar));

  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcOut) && $stable(gOut)));

  // R3
  g_only_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (gOut != $past(gOut)) |-> $past(strobe.ldG));

  // R2
  pc_step_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcOut != $past(pcOut)) |-> (pcOut == $past(pcOut) + ADDR_W'(1)));
endmodule

bind sbus_cpu sbus_cpu_chk u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe),
  .halted(halted), .pcOut(pcOut), .gOut(gOut)
);

// File: tb/sbus_cpu_bench.sv
module sbus_cpu_bench;
  localparam int MEM_AW = 6;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memWrEn = 1'b0;
  logic [5:0]  memWrAddr = '0;
  logic [15:0] memWrData = '0;
  logic        halted;
  logic [11:0] pcOut;
  logic [15:0] gOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  sbus_cpu #(.MEM_AW(MEM_AW)) u_sbus_cpu (
    .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .halted(halted), .pcOut(pcOut), .gOut(gOut)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic writeWord(input int addr, input logic [15:0] data);
    @(negedge clk);
    memWrEn = 1'b1; memWrAddr = 6'(addr); memWrData = data;
    @(negedge clk);
    memWrEn = 1'b0;
  endtask

  // hold reset, clear memory, then write program words from address 0
  task automatic loadProgram(input logic [15:0] words[$]);
    @(negedge clk);
    rstN = 1'b0;
    for (int a = 0; a < DEPTH; a++) writeWord(a, 16'h0000);
    foreach (words[i]) writeWord(i, words[i]);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // advance to just after edge n counted from reset release
  int edgeNow;
  task automatic toEdge(input int n);
    while (edgeNow < n) begin
      @(posedge clk);
      edgeNow++;
    end
    #1;
  endtask

  task automatic testSampleProgram();
    loadProgram('{16'hFFFF, 16'h6004, 16'h0000, 16'h0000, 16'hBBBB});
    check(pcOut == 0 && !halted && gOut == 0, "R1", "state in reset",
          {halted, 3'b0, pcOut}, 16'h0000);
    release_reset(); edgeNow = 0;
    toEdge(0);
    check(pcOut == 0 && !halted && gOut == 0, "R1", "first cycle after reset",
          gOut, 16'h0000);
    toEdge(22);
    check(gOut == 16'h0000, "R3", "G before load edge", gOut, 16'h0000);
    toEdge(23);
    check(gOut == 16'hBBBB, "R3", "G at load edge", gOut, 16'hBBBB);
    toEdge(30);
    check(halted == 1'b0, "R4", "halted before halt edge", 16'(halted), 16'h0);
    toEdge(31);
    check(halted == 1'b1, "R4", "halted at halt edge", 16'(halted), 16'h1);
    check(pcOut == 12'd3, "R9", "PC after halt", 16'(pcOut), 16'h3);
    check(gOut == 16'hBBBB, "R9", "G after halt", gOut, 16'hBBBB);
    toEdge(80);
    check(halted && pcOut == 12'd3 && gOut == 16'hBBBB, "R8", "frozen after halt",
          gOut, 16'hBBBB);
  endtask

  task automatic testResetAfterHalt();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(pcOut == 0 && !halted && gOut == 0, "R1", "reset clears halted run",
          {halted, 3'b0, pcOut}, 16'h0000);
    check(gOut == 16'h0000, "R1", "reset clears G", gOut, 16'h0000);
  endtask

  task automatic testNopPath();
    loadProgram('{16'hFFFF, 16'h1234, 16'hA000, 16'h0000});
    release_reset(); edgeNow = 0;
    toEdge(5);
    check(pcOut == 12'd0, "R2", "PC before increment edge", 16'(pcOut), 16'h0);
    toEdge(6);
    check(pcOut == 12'd1, "R2", "PC at increment edge", 16'(pcOut), 16'h1);
    toEdge(18);
    check(pcOut == 12'd2, "R5", "PC after opcode 1", 16'(pcOut), 16'h2);
    toEdge(30);
    check(pcOut == 12'd3 && !halted, "R5", "PC after opcode A", 16'(pcOut), 16'h3);
    check(gOut == 16'h0000, "R5", "G untouched by no-ops", gOut, 16'h0000);
    toEdge(42);
    check(halted == 1'b0, "R4", "not halted before edge 43", 16'(halted), 16'h0);
    toEdge(43);
    check(halted == 1'b1 && pcOut == 12'd4, "R4", "halt at edge 43, PC 4",
          16'(pcOut), 16'h4);
  endtask

  task automatic testTwoLoads();
    logic [15:0] prog[$];
    prog = '{16'h603F, 16'h6001, 16'h0000};
    loadProgram(prog);
    writeWord(63, 16'h8001);
    release_reset(); edgeNow = 0;
    toEdge(11);
    check(gOut == 16'h8001, "R3", "load from top address", gOut, 16'h8001);
    toEdge(23);
    check(gOut == 16'h6001, "R3", "second load overwrites G", gOut, 16'h6001);
    toEdge(31);
    check(halted && pcOut == 12'd3, "R4", "halt after two loads", 16'(pcOut), 16'h3);
  endtask

  initial begin
    testSampleProgram();
    testResetAfterHalt();
    testNopPath();
    testTwoLoads();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule